// File: doc/BRIEF.md
# Cascadable Countdown Timer Group

A group of four programmable down-counting timers behind a simple word-addressed register bus. Every timer owns a reload value, a live count and two general storage words. One prescaler, set in a shared group control word, paces all four timers. A running timer steps its count down by one on each prescaled tick. When it steps at zero it pulses its interrupt line and reloads.

Neighbouring timers can be chained in pairs, so that a single long interval is counted. The lower-numbered timer is the fast digit and the higher-numbered timer is the slow digit. A chained pair is started and stopped through the hold bit of its upper timer, and only the upper timer interrupts. The bus writes on the rising clock edge where `wr_i` is high. Reads are combinational from `addr_i`.

Top module: `casc_timer_group`

## Requirements
- R1: After reset every count, storage word and the group control word read 0. Every reload word reads 0x8000_0000, and no interrupt line is high.
- R2: Timer n sits at byte address n*0x40, with the live count at +0x00, the reload word at +0x10 and the two storage words at +0x20 and +0x30. The group control word is at 0x100. Storage words read back what was written.
- R3: While bit 31 of a timer's reload word is 1 and the timer is not the lower half of a chain, its count does not change. A write of a reload word with bit 31 set also loads the count with bits 30:0 of the written data.
- R4: Group control bits 9:8 pick the tick period in clock cycles: 0→8, 1→16, 2→32, 3→64. Over any window of 10 periods a running count drops by exactly 10.
- R5: When a stand-alone timer is stepped while its count is zero, it raises its interrupt for exactly one cycle and reloads bits 30:0 of its reload word. Its interrupts are therefore (reload+1) tick periods apart.
- R6: A write to a live count register reloads the count from the reload word, and the written data is ignored.
- R7: Pair p (timers p and p+1, with p from 0 to 2) is chained only when group control bit p and bit p+24 are both 1. With either bit alone the two timers run independently. Only bits 26:24, 9:8 and 2:0 of the group control word are stored; the other bits read 0.
- R8: In a chained pair, the lower timer steps on ticks. When it steps at zero it reloads all 32 bits of its reload word and steps the upper timer. The upper timer interrupts when it is stepped at zero. The lower timer never interrupts, so the pair's period is (U+1)*(L+1) ticks.
- R9: In a chained pair, the pair runs only while bit 31 of the upper timer's reload word is 0. The lower timer's bit 31 has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 9 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 4 | Per-timer expiry pulse |

## Verification
Interrupt spacing is measured between two consecutive pulses, so the check does not depend on the free-running prescaler phase. An off-by-one in the reload would show up as a period of base ticks instead of base+1. A prescaler that is wrong shows up as a count that drops by the wrong amount over a fixed window of cycles.

For a chained pair, the bench checks three things. It checks the period product. It checks that the lower timer stays silent. It checks that the pair stays frozen while the lower timer's hold bit is clear but the upper timer's is set. A chain that keyed on the cascade bit alone would fail when only that bit is set. A chain that used the lower timer's own hold bit would fail the frozen-pair check. The bench also checks that a count write reloads from the reload word and does not take the written data.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int unsigned NUM_TMR       = 4;
  localparam int unsigned NUM_PAIRS     = NUM_TMR - 1;
  localparam int unsigned DW            = 32;
  localparam int unsigned AW            = 9;
  localparam int unsigned PSC_W         = 2;
  localparam int unsigned BASE_DIV_LOG2 = 3;
  localparam int unsigned PSC_CNT_W     = BASE_DIV_LOG2 + (1 << PSC_W) - 1;
  localparam int unsigned TSEL_W        = $clog2(NUM_TMR);
  localparam int unsigned RSEL_LSB      = 4;
  localparam int unsigned TSEL_LSB      = 6;
  localparam int unsigned CASC_LSB      = 0;
  localparam int unsigned DIV_LSB       = 8;
  localparam int unsigned ROLL_LSB      = 24;
  localparam logic [AW-1:0] CTRL_ADDR   = AW'(9'h100);
  localparam logic [DW-1:0] CTRL_MASK   =
      DW'(((1 << NUM_PAIRS) - 1) << ROLL_LSB) |
      DW'(((1 << NUM_PAIRS) - 1) << CASC_LSB) |
      DW'(((1 << PSC_W) - 1) << DIV_LSB);

  typedef enum logic [1:0] {
    RS_CUR  = 2'd0,
    RS_BASE = 2'd1,
    RS_VEC  = 2'd2,
    RS_DST  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tg_prescaler.sv
module tg_prescaler
  import tg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PSC_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PSC_CNT_W-1:0] cnt_q;
  logic [PSC_CNT_W-1:0] lim;

  always_comb begin
    lim = '0;
    for (int k = 0; k < (1 << PSC_W); k++) begin
      if (sel_i == PSC_W'(k)) lim = PSC_CNT_W'((1 << (BASE_DIV_LOG2 + k)) - 1);
    end
  end

  // >= so that a shorter divider selected mid-count still wraps at once
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tg_channel.sv
module tg_channel
  import tg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  reg_sel_e      sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          step_i,
  input  logic          wide_i,
  output logic [DW-1:0] cur_o,
  output logic [DW-1:0] base_o,
  output logic [DW-1:0] vec_o,
  output logic [DW-1:0] dst_o,
  output logic          wrap_o
);
  logic [DW-1:0] cur_q, base_q, vec_q, dst_q;
  logic [DW-1:0] reload;
  logic          ld_cur;
  logic [DW-1:0] ld_val;

  // lower half of a chain uses every bit of its reload word
  assign reload = wide_i ? base_q : {1'b0, base_q[DW-2:0]};
  assign wrap_o = step_i && (cur_q == '0);

  always_comb begin
    ld_cur = 1'b0;
    ld_val = reload;
    if (wr_i && sel_i == RS_CUR) begin
      ld_cur = 1'b1;
    end else if (wr_i && sel_i == RS_BASE && wdata_i[DW-1]) begin
      ld_cur = 1'b1;
      ld_val = {1'b0, wdata_i[DW-2:0]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
    end else if (ld_cur) begin
      cur_q <= ld_val;
    end else if (step_i) begin
      cur_q <= wrap_o ? reload : cur_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= DW'(1) << (DW - 1);
      vec_q  <= '0;
      dst_q  <= '0;
    end else if (wr_i) begin
      case (sel_i)
        RS_BASE: base_q <= wdata_i;
        RS_VEC:  vec_q  <= wdata_i;
        RS_DST:  dst_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  assign cur_o  = cur_q;
  assign base_o = base_q;
  assign vec_o  = vec_q;
  assign dst_o  = dst_q;
endmodule

// File: rtl/casc_timer_group.sv
module casc_timer_group
  import tg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic [NUM_TMR-1:0] irq_o
);
  logic [DW-1:0]                ctrl_q;
  logic                         tick_w;
  logic [NUM_PAIRS-1:0]         chained_w;
  logic [NUM_TMR-1:0][DW-1:0]   cur_w, base_w, vec_w, dst_w;
  logic                         gate_w [NUM_TMR];
  logic                         step_w [NUM_TMR];
  logic                         wrap_w [NUM_TMR];
  logic                         wide_w [NUM_TMR];
  logic                         hit_ctrl, hit_tmr;
  logic [TSEL_W-1:0]            tsel;
  reg_sel_e                     rsel;

  assign hit_ctrl = (addr_i == CTRL_ADDR);
  assign hit_tmr  = !addr_i[AW-1] && (addr_i[RSEL_LSB-1:0] == '0);
  assign tsel     = addr_i[TSEL_LSB +: TSEL_W];
  assign rsel     = reg_sel_e'(addr_i[RSEL_LSB +: 2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ctrl_q <= '0;
    else if (wr_i && hit_ctrl)  ctrl_q <= wdata_i & CTRL_MASK;
  end

  tg_prescaler u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (ctrl_q[DIV_LSB +: PSC_W]),
    .tick_o (tick_w)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign chained_w[p] = ctrl_q[CASC_LSB + p] & ctrl_q[ROLL_LSB + p];
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    // run permission comes from the top of the chain
    if (i == NUM_TMR - 1) begin : g_top
      assign gate_w[i] = !base_w[i][DW-1];
      assign wide_w[i] = 1'b0;
    end else begin : g_mid
      assign gate_w[i] = chained_w[i] ? gate_w[i+1] : !base_w[i][DW-1];
      assign wide_w[i] = chained_w[i];
    end

    if (i == 0) begin : g_first
      assign step_w[i] = tick_w & gate_w[i];
    end else begin : g_next
      assign step_w[i] = chained_w[i-1] ? wrap_w[i-1] : (tick_w & gate_w[i]);
    end

    assign irq_o[i] = wrap_w[i] & !wide_w[i];

    tg_channel u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_i && hit_tmr && (tsel == TSEL_W'(i))),
      .sel_i   (rsel),
      .wdata_i (wdata_i),
      .step_i  (step_w[i]),
      .wide_i  (wide_w[i]),
      .cur_o   (cur_w[i]),
      .base_o  (base_w[i]),
      .vec_o   (vec_w[i]),
      .dst_o   (dst_w[i]),
      .wrap_o  (wrap_w[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl) begin
      rdata_o = ctrl_q;
    end else if (hit_tmr) begin
      case (rsel)
        RS_CUR:  rdata_o = cur_w[tsel];
        RS_BASE: rdata_o = base_w[tsel];
        RS_VEC:  rdata_o = vec_w[tsel];
        RS_DST:  rdata_o = dst_w[tsel];
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/tg_checker.sv
module tg_checker
  import tg_pkg::*;
(
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       wr_i,
  input logic                       tick_w,
  input logic [NUM_PAIRS-1:0]       chained_w,
  input logic [NUM_TMR-1:0][DW-1:0] base_w,
  input logic [NUM_TMR-1:0][DW-1:0] cur_w,
  input logic [NUM_TMR-1:0]         irq_o
);
  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_w |=> !tick_w); // R4

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |=> (irq_o == '0)); // R5

  AST_IRQ_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> tick_w); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_w[0][DW-1] && !chained_w[0] && !wr_i) |=> $stable(cur_w[0])); // R3

  AST_LOWER_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chained_w[0] |-> !irq_o[0]); // R8
endmodule

bind casc_timer_group tg_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .tick_w    (tick_w),
  .chained_w (chained_w),
  .base_w    (base_w),
  .cur_w     (cur_w),
  .irq_o     (irq_o)
);

// File: tb/sim_casc_timer_group.sv
module sim_casc_timer_group;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;
  int irq_cnt [4];
  int last_t [4];
  int prev_t [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  casc_timer_group u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  initial for (int i = 0; i < 4; i++) begin irq_cnt[i] = 0; last_t[i] = 0; prev_t[i] = 0; end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < 4; i++) if (irq[i]) begin
      irq_cnt[i] <= irq_cnt[i] + 1;
      prev_t[i]  <= last_t[i];
      last_t[i]  <= cyc;
    end
  end

  function automatic logic [8:0] ta(int n, int r);
    return 9'(n * 64 + r * 16);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [8:0] a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(logic [8:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  // waits for n more pulses on timer i, returns spacing of the last two
  task automatic irq_interval(int i, int n, output int gap);
    int start = irq_cnt[i];
    int t = 0;
    while (irq_cnt[i] < start + n && t < 5000) begin @(negedge clk); t++; end
    gap = (irq_cnt[i] >= start + n) ? (last_t[i] - prev_t[i]) : -1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int n = 0; n < 4; n++) begin
      rd_reg(ta(n, 0), v); chk("R1 cur", v, 32'h0);
      rd_reg(ta(n, 1), v); chk("R1 base", v, 32'h8000_0000);
      rd_reg(ta(n, 2), v); chk("R1 vec", v, 32'h0);
      rd_reg(ta(n, 3), v); chk("R1 dst", v, 32'h0);
    end
    rd_reg(9'h100, v); chk("R1 ctrl", v, 32'h0);
    chk("R1 irq", {28'h0, irq}, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr_reg(ta(2, 2), 32'hA5A5_0003);
    wr_reg(ta(3, 3), 32'h0000_00F1);
    rd_reg(ta(2, 2), v); chk("R2 vec2", v, 32'hA5A5_0003);
    rd_reg(ta(3, 3), v); chk("R2 dst3", v, 32'h0000_00F1);
    rd_reg(ta(3, 2), v); chk("R2 vec3 untouched", v, 32'h0);
    wr_reg(9'h100, 32'hFFFF_FFFF);
    rd_reg(9'h100, v); chk("R7 ctrl mask", v, 32'h0700_0307);
    wr_reg(9'h100, 32'h0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    int g;
    wr_reg(ta(0, 1), 32'h8000_0003);
    rd_reg(ta(0, 0), v); chk("R3 load on hold", v, 32'h3);
    wr_reg(ta(0, 1), 32'h0000_0003);
    irq_interval(0, 3, g); chk("R5 period base+1", 32'(g), 32'd32);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    int c0;
    wr_reg(ta(0, 1), 32'h8000_0005);
    c0 = irq_cnt[0];
    repeat (200) @(negedge clk);
    rd_reg(ta(0, 0), v); chk("R3 held count", v, 32'h5);
    chk("R3 no irq while held", 32'(irq_cnt[0] - c0), 32'h0);
  endtask

  task automatic t_decr();
    logic [31:0] a, b;
    wr_reg(ta(1, 1), 32'h8000_03E8);
    wr_reg(ta(1, 1), 32'h0000_03E8);
    rd_reg(ta(1, 0), a);
    repeat (79) @(negedge clk);
    rd_reg(ta(1, 0), b);
    chk("R4 ten ticks div8", a - b, 32'd10);
    wr_reg(9'h100, 32'h0000_0300);
    rd_reg(ta(1, 0), a);
    repeat (639) @(negedge clk);
    rd_reg(ta(1, 0), b);
    chk("R4 ten ticks div64", a - b, 32'd10);
    wr_reg(ta(1, 0), 32'h0000_1234);
    rd_reg(ta(1, 0), a);
    chk("R6 count write reloads", a, 32'h3E8);
    wr_reg(ta(1, 1), 32'h8000_03E8);
    wr_reg(9'h100, 32'h0);
  endtask

  task automatic t_psc();
    int g;
    wr_reg(9'h100, 32'h0000_0200);
    wr_reg(ta(2, 1), 32'h8000_0001);
    wr_reg(ta(2, 1), 32'h0000_0001);
    irq_interval(2, 3, g); chk("R4 div32 period", 32'(g), 32'd64);
    wr_reg(9'h100, 32'h0000_0100);
    irq_interval(2, 3, g); chk("R4 div16 period", 32'(g), 32'd32);
    wr_reg(ta(2, 1), 32'h8000_0001);
    wr_reg(9'h100, 32'h0);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    int g, c0;
    wr_reg(9'h100, 32'h0100_0001);
    wr_reg(ta(0, 1), 32'h8000_0002);
    wr_reg(ta(0, 1), 32'h0000_0002);
    wr_reg(ta(1, 1), 32'h8000_0001);
    repeat (100) @(negedge clk);
    rd_reg(ta(0, 0), v); chk("R9 pair frozen by upper", v, 32'h2);
    rd_reg(ta(1, 0), v); chk("R9 upper frozen", v, 32'h1);
    c0 = irq_cnt[0];
    wr_reg(ta(1, 1), 32'h0000_0001);
    irq_interval(1, 3, g); chk("R8 chained period", 32'(g), 32'd48);
    chk("R8 lower silent", 32'(irq_cnt[0] - c0), 32'h0);
    wr_reg(ta(1, 1), 32'h8000_0001);
    wr_reg(9'h100, 32'h0);
    wr_reg(ta(0, 1), 32'h8000_0000);
  endtask

  task automatic t_half();
    int g, c1;
    wr_reg(9'h100, 32'h0000_0001);
    c1 = irq_cnt[1];
    wr_reg(ta(0, 1), 32'h8000_0001);
    wr_reg(ta(0, 1), 32'h0000_0001);
    irq_interval(0, 3, g); chk("R7 cascade bit alone", 32'(g), 32'd16);
    chk("R7 neighbour quiet", 32'(irq_cnt[1] - c1), 32'h0);
    wr_reg(ta(0, 1), 32'h8000_0001);
    wr_reg(9'h100, 32'h0100_0000);
    wr_reg(ta(0, 1), 32'h0000_0001);
    irq_interval(0, 3, g); chk("R7 rollover bit alone", 32'(g), 32'd16);
    wr_reg(ta(0, 1), 32'h8000_0001);
    wr_reg(9'h100, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_single();
    t_hold();
    t_decr();
    t_psc();
    t_chain();
    t_half();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule